// File: doc/BRIEF.md
# Low-Power Mode Controller With Retention

This controller chooses the chip's power mode. The four modes are Active, Doze, Deep-sleep and Power-down. It drives five outputs: the always-on regulator enable, the core domain power enable, the analog and radio domain enables, and the main clock enable. It also issues one-cycle strobes that start a save of core state into an always-on retention store, and a restore of that state.

Software asks for a mode by pulsing `mode_req_vld` with a 2-bit code on `mode_req`. There are three wake sources: an external interrupt, a host resume on the SDIO bus, and a sequencer timer. They are given as bits 0, 1 and 2 of `wake_src`.

A Deep-sleep request runs the following sequence:

1. A save strobe is issued.
2. The controller waits for the save acknowledgement.
3. Core power and the clock are removed.
4. It waits in sleep for a wake.
5. Core power and the clock are restored, and a restore strobe is issued.
6. On the restore acknowledgement, it returns to Active.

A wake that arrives during the save is remembered. The restore then begins straight after one sleep cycle.

Power-down turns off every regulator. Only the external regulator re-enable input brings the block out of Power-down.

The state machine has eight named states. ACTIVE, DOZE and PDOWN are the three steady modes outside Deep-sleep. SAVE_GO issues the save strobe, and SAVE_WAIT waits for the save acknowledgement. SLEEP is the state with the core powered off. REST_GO issues the restore strobe, and REST_WAIT waits for the restore acknowledgement.

The transitions are:

- ACTIVE→DOZE on a Doze request.
- ACTIVE→SAVE_GO on a Deep-sleep request.
- ACTIVE→PDOWN on a Power-down request.
- DOZE→ACTIVE on a wake or an Active request.
- SAVE_GO→SAVE_WAIT always.
- SAVE_WAIT→SLEEP on the save acknowledgement.
- SLEEP→REST_GO on a current or latched wake.
- REST_GO→REST_WAIT always.
- REST_WAIT→ACTIVE on the restore acknowledgement.
- PDOWN→ACTIVE on regulator re-enable.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset the block is in Active. The regulator, core, analog, radio and clock enables are all 1, both strobes are 0, and `mode_status` is 00. The status codes are 00 Active, 01 Doze, 10 Deep-sleep and 11 Power-down, and `mode_req` uses the same codes.
- R2: A request is sampled at the clock edge where `mode_req_vld` is 1. The outputs show the new mode from that edge on, which is one cycle after the request is driven.
- R3: In Doze, the main clock, radio and analog enables are 0, and the core and regulator enables stay 1. Any wake bit or an Active request returns the block to Active at the next edge.
- R4: A Deep-sleep request gives `save_start` high for exactly one cycle, then waits. The core and clock stay on until `save_done` is sampled. From that edge on, the core and clock enables are 0 and the status is 10.
- R5: In sleep, any one of the three wake bits gives, at the next edge, the core and clock enables at 1 and a one-cycle `restore_start`. The block reaches Active at the edge that samples `restore_done`.
- R6: A wake that is seen while the save strobe or save wait is in progress is latched. After one sleep cycle, the restore begins with no further wake.
- R7: In Power-down, every enable is 0 and the status is 11. Wake bits have no effect. A `reg_reenable` pulse returns the block to Active at the next edge.
- R8: A wake pulse received in Active is not remembered. A later Deep-sleep entry stays in sleep until a new wake arrives.
- R9: Mode requests are ignored outside Active. The one exception is an Active request in Doze. For example, a Power-down request in sleep or in Power-down leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req_vld | input | 1 | Mode request valid pulse |
| mode_req | input | 2 | Requested mode code |
| wake_src | input | 3 | Wake sources: bit0 interrupt, bit1 host resume, bit2 timer |
| save_done | input | 1 | Retention save acknowledgement |
| restore_done | input | 1 | Retention restore acknowledgement |
| reg_reenable | input | 1 | External regulator re-enable |
| reg_en | output | 1 | Internal regulator enable |
| core_pwr_en | output | 1 | Digital core domain power enable |
| analog_pwr_en | output | 1 | Analog domain power enable |
| radio_pwr_en | output | 1 | Radio domain power enable |
| main_clk_en | output | 1 | Main clock enable |
| save_start | output | 1 | Save-to-retention strobe |
| restore_start | output | 1 | Restore-from-retention strobe |
| mode_status | output | 2 | Current mode code |

## Verification
Every output comes straight from the state register. Each result is therefore due exactly one clock edge after the cycle in which its stimulus is driven. Multi-step sequences are made of chains of such single-edge steps. For example, the save strobe is due one edge after the request, and power-off one edge after `save_done`. The driver applies each cycle's inputs at the falling edge and queues the outputs expected after the next rising edge. The monitor pops the queue and compares 2 ns after that rising edge, so each comparison lands on the cycle in which the result is due.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_ACTIVE = 2'b00,
        MODE_DOZE   = 2'b01,
        MODE_DEEP   = 2'b10,
        MODE_PDOWN  = 2'b11
    } lpm_mode_e;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_DOZE,
        ST_SAVE_GO,
        ST_SAVE_WAIT,
        ST_SLEEP,
        ST_REST_GO,
        ST_REST_WAIT,
        ST_PDOWN
    } lpm_state_e;

    typedef struct packed {
        lpm_mode_e mode;
        logic      reg_on;
        logic      core_on;
        logic      analog_on;
        logic      radio_on;
        logic      clk_on;
        logic      save_go;
        logic      rest_go;
    } lpm_out_t;
endpackage

// File: rtl/lpm_wake_latch.sv
module lpm_wake_latch #(
    parameter int N_WAKE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WAKE-1:0] wake_src,
    input  logic              arm,
    input  logic              clr,
    output logic              wake_now,
    output logic              wake_pend
);
    logic [N_WAKE-1:0] sticky_q;

    generate
        for (genvar i = 0; i < N_WAKE; i++) begin : g_src
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    sticky_q[i] <= 1'b0;
                else if (clr)
                    sticky_q[i] <= 1'b0;
                else if (arm && wake_src[i])
                    sticky_q[i] <= 1'b1;
            end
        end
    endgenerate

    assign wake_now  = |wake_src;
    assign wake_pend = (|sticky_q) | (arm & wake_now);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [MODE_W-1:0] req,
    input  logic              wake_now,
    input  logic              wake_pend,
    input  logic              save_done,
    input  logic              restore_done,
    input  logic              reg_reenable,
    output lpm_out_t          outs,
    output logic              wake_arm,
    output logic              wake_clr
);
    lpm_state_e state_q, state_d;
    lpm_mode_e  req_mode;

    assign req_mode = lpm_mode_e'(req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_ACTIVE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (req_vld) begin
                    unique case (req_mode)
                        MODE_DOZE:   state_d = ST_DOZE;
                        MODE_DEEP:   state_d = ST_SAVE_GO;
                        MODE_PDOWN:  state_d = ST_PDOWN;
                        MODE_ACTIVE: state_d = ST_ACTIVE;
                    endcase
                end
            end
            ST_DOZE: begin
                if (wake_now || (req_vld && req_mode == MODE_ACTIVE))
                    state_d = ST_ACTIVE;
            end
            ST_SAVE_GO:   state_d = ST_SAVE_WAIT;
            ST_SAVE_WAIT: if (save_done) state_d = ST_SLEEP;
            ST_SLEEP:     if (wake_pend) state_d = ST_REST_GO;
            ST_REST_GO:   state_d = ST_REST_WAIT;
            ST_REST_WAIT: if (restore_done) state_d = ST_ACTIVE;
            ST_PDOWN:     if (reg_reenable) state_d = ST_ACTIVE;
        endcase
    end

    always_comb begin
        outs           = '0;
        outs.mode      = MODE_ACTIVE;
        wake_arm       = 1'b0;
        wake_clr       = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                outs.reg_on    = 1'b1;
                outs.core_on   = 1'b1;
                outs.analog_on = 1'b1;
                outs.radio_on  = 1'b1;
                outs.clk_on    = 1'b1;
            end
            ST_DOZE: begin
                outs.mode    = MODE_DOZE;
                outs.reg_on  = 1'b1;
                outs.core_on = 1'b1;
            end
            ST_SAVE_GO: begin
                outs.mode    = MODE_DEEP;
                outs.reg_on  = 1'b1;
                outs.core_on = 1'b1;
                outs.clk_on  = 1'b1;
                outs.save_go = 1'b1;
                wake_arm     = 1'b1;
            end
            ST_SAVE_WAIT: begin
                outs.mode    = MODE_DEEP;
                outs.reg_on  = 1'b1;
                outs.core_on = 1'b1;
                outs.clk_on  = 1'b1;
                wake_arm     = 1'b1;
            end
            ST_SLEEP: begin
                outs.mode    = MODE_DEEP;
                outs.reg_on  = 1'b1;
                wake_arm     = 1'b1;
            end
            ST_REST_GO: begin
                outs.mode    = MODE_DEEP;
                outs.reg_on  = 1'b1;
                outs.core_on = 1'b1;
                outs.clk_on  = 1'b1;
                outs.rest_go = 1'b1;
                wake_clr     = 1'b1;
            end
            ST_REST_WAIT: begin
                outs.mode    = MODE_DEEP;
                outs.reg_on  = 1'b1;
                outs.core_on = 1'b1;
                outs.clk_on  = 1'b1;
            end
            ST_PDOWN: begin
                outs.mode = MODE_PDOWN;
            end
        endcase
    end
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
    import lpm_pkg::*;
#(
    parameter int N_WAKE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req_vld,
    input  logic [1:0]        mode_req,
    input  logic [N_WAKE-1:0] wake_src,
    input  logic              save_done,
    input  logic              restore_done,
    input  logic              reg_reenable,
    output logic              reg_en,
    output logic              core_pwr_en,
    output logic              analog_pwr_en,
    output logic              radio_pwr_en,
    output logic              main_clk_en,
    output logic              save_start,
    output logic              restore_start,
    output logic [1:0]        mode_status
);
    lpm_out_t outs;
    logic     wake_now, wake_pend, wake_arm, wake_clr;

    lpm_wake_latch #(.N_WAKE(N_WAKE)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_src  (wake_src),
        .arm       (wake_arm),
        .clr       (wake_clr),
        .wake_now  (wake_now),
        .wake_pend (wake_pend)
    );

    lpm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_vld      (mode_req_vld),
        .req          (mode_req),
        .wake_now     (wake_now),
        .wake_pend    (wake_pend),
        .save_done    (save_done),
        .restore_done (restore_done),
        .reg_reenable (reg_reenable),
        .outs         (outs),
        .wake_arm     (wake_arm),
        .wake_clr     (wake_clr)
    );

    assign reg_en        = outs.reg_on;
    assign core_pwr_en   = outs.core_on;
    assign analog_pwr_en = outs.analog_on;
    assign radio_pwr_en  = outs.radio_on;
    assign main_clk_en   = outs.clk_on;
    assign save_start    = outs.save_go;
    assign restore_start = outs.rest_go;
    assign mode_status   = outs.mode;
endmodule

// File: rtl/lpm_checks.sv
module lpm_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       save_done,
    input logic       restore_done,
    input logic       reg_reenable,
    input logic       reg_en,
    input logic       core_pwr_en,
    input logic       analog_pwr_en,
    input logic       radio_pwr_en,
    input logic       main_clk_en,
    input logic       save_start,
    input logic       restore_start,
    input logic [1:0] mode_status
);
    // R3: doze keeps core up with clocks and RF/analog off
    assert_doze_domains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status == 2'b01 |-> (core_pwr_en && !main_clk_en && !radio_pwr_en && !analog_pwr_en));

    // R4: core power drops in deep sleep only after save acknowledgement
    assert_save_before_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_pwr_en) && mode_status == 2'b10) |-> $past(save_done));

    // R4: save strobe lasts one cycle
    assert_save_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        save_start |=> !save_start);

    // R5: restore strobe lasts one cycle
    assert_restore_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restore_start |=> !restore_start);

    // R5: leaving deep sleep for Active needs restore acknowledgement
    assert_restore_before_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_status) == 2'b10 && mode_status == 2'b00) |-> $past(restore_done));

    // R7: power-down turns everything off
    assert_pdown_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status == 2'b11 |-> (!reg_en && !core_pwr_en && !main_clk_en && !radio_pwr_en && !analog_pwr_en));

    // R7: power-down is left only via regulator re-enable
    assert_pdown_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_status) == 2'b11 && mode_status != 2'b11) |-> $past(reg_reenable));
endmodule

bind lp_mode_ctrl lpm_checks u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .save_done     (save_done),
    .restore_done  (restore_done),
    .reg_reenable  (reg_reenable),
    .reg_en        (reg_en),
    .core_pwr_en   (core_pwr_en),
    .analog_pwr_en (analog_pwr_en),
    .radio_pwr_en  (radio_pwr_en),
    .main_clk_en   (main_clk_en),
    .save_start    (save_start),
    .restore_start (restore_start),
    .mode_status   (mode_status)
);

// File: tb/lp_mode_ctrl_test.sv
`timescale 1ns/1ps
module lp_mode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_req_vld = 1'b0;
    logic [1:0] mode_req = 2'b00;
    logic [2:0] wake_src = 3'b000;
    logic       save_done = 1'b0, restore_done = 1'b0, reg_reenable = 1'b0;
    logic       reg_en, core_pwr_en, analog_pwr_en, radio_pwr_en, main_clk_en;
    logic       save_start, restore_start;
    logic [1:0] mode_status;

    // {status, reg, core, analog, radio, clk, save, restore}
    localparam logic [8:0] V_ACT = 9'b00_11111_00;
    localparam logic [8:0] V_DOZ = 9'b01_11000_00;
    localparam logic [8:0] V_SVG = 9'b10_11001_10;
    localparam logic [8:0] V_SVW = 9'b10_11001_00;
    localparam logic [8:0] V_SLP = 9'b10_10000_00;
    localparam logic [8:0] V_RSG = 9'b10_11001_01;
    localparam logic [8:0] V_RSW = 9'b10_11001_00;
    localparam logic [8:0] V_PDN = 9'b11_00000_00;

    int unsigned n_vec = 0, n_bad = 0;
    bit          done = 1'b0;
    logic [8:0]  exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    lp_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_req_vld(mode_req_vld), .mode_req(mode_req),
        .wake_src(wake_src), .save_done(save_done), .restore_done(restore_done),
        .reg_reenable(reg_reenable), .reg_en(reg_en), .core_pwr_en(core_pwr_en),
        .analog_pwr_en(analog_pwr_en), .radio_pwr_en(radio_pwr_en),
        .main_clk_en(main_clk_en), .save_start(save_start),
        .restore_start(restore_start), .mode_status(mode_status)
    );

    function automatic logic [8:0] actual();
        return {mode_status, reg_en, core_pwr_en, analog_pwr_en, radio_pwr_en,
                main_clk_en, save_start, restore_start};
    endfunction

    task automatic compare(input logic [8:0] exp, input string tag);
        n_vec++;
        if (actual() !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, actual(), exp);
        end
    endtask

    // driver: one cycle of inputs, expected outputs after next rising edge
    task automatic step(input logic vld, input logic [1:0] req, input logic [2:0] wk,
                        input logic sd, input logic rd, input logic re,
                        input logic [8:0] exp, input string tag);
        @(negedge clk);
        mode_req_vld = vld; mode_req = req; wake_src = wk;
        save_done = sd; restore_done = rd; reg_reenable = re;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [8:0] exp, input string tag);
        step(1'b0, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0, exp, tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 compare(V_ACT, "R1 reset state");
        @(negedge clk) rst_n = 1'b1;

        idle(V_ACT, "R1 idle after reset");
        // Doze entry and exits
        step(1, 2'b01, 3'b000, 0, 0, 0, V_DOZ, "R2 doze request");
        idle(V_DOZ, "R3 doze holds");
        step(0, 2'b00, 3'b010, 0, 0, 0, V_ACT, "R3 doze host wake");
        step(1, 2'b01, 3'b000, 0, 0, 0, V_DOZ, "R2 doze again");
        step(1, 2'b11, 3'b000, 0, 0, 0, V_DOZ, "R9 pdown request in doze");
        step(1, 2'b00, 3'b000, 0, 0, 0, V_ACT, "R3 active request leaves doze");
        // stale wake in Active then deep sleep
        step(0, 2'b00, 3'b001, 0, 0, 0, V_ACT, "R8 wake in active");
        step(1, 2'b10, 3'b000, 0, 0, 0, V_SVG, "R4 save strobe");
        idle(V_SVW, "R4 save wait");
        idle(V_SVW, "R4 core held until done");
        step(0, 2'b00, 3'b000, 1, 0, 0, V_SLP, "R4 power off after done");
        idle(V_SLP, "R8 no stale wake");
        idle(V_SLP, "R8 still asleep");
        step(1, 2'b11, 3'b000, 0, 0, 0, V_SLP, "R9 pdown request in sleep");
        step(0, 2'b00, 3'b100, 0, 0, 0, V_RSG, "R5 timer wake restore strobe");
        idle(V_RSW, "R5 restore wait");
        step(0, 2'b00, 3'b000, 0, 1, 0, V_ACT, "R5 active after restore done");
        // wake latched during save
        step(1, 2'b10, 3'b000, 0, 0, 0, V_SVG, "R4 save strobe 2");
        step(0, 2'b00, 3'b001, 0, 0, 0, V_SVW, "R6 wake during save");
        step(0, 2'b00, 3'b000, 1, 0, 0, V_SLP, "R6 power off completes");
        idle(V_RSG, "R6 latched wake restores");
        idle(V_RSW, "R6 restore wait");
        step(0, 2'b00, 3'b000, 0, 1, 0, V_ACT, "R6 back to active");
        // host resume wake from sleep
        step(1, 2'b10, 3'b000, 0, 0, 0, V_SVG, "R4 save strobe 3");
        step(0, 2'b00, 3'b000, 1, 0, 0, V_SVW, "R4 done ignored during strobe");
        step(0, 2'b00, 3'b000, 1, 0, 0, V_SLP, "R4 off after done");
        idle(V_SLP, "R6 latch cleared after restore");
        step(0, 2'b00, 3'b010, 0, 0, 0, V_RSG, "R5 host wake restore strobe");
        step(0, 2'b00, 3'b000, 0, 1, 0, V_RSW, "R5 done ignored during strobe");
        step(0, 2'b00, 3'b000, 0, 1, 0, V_ACT, "R5 active after done");
        // power-down
        step(1, 2'b11, 3'b000, 0, 0, 0, V_PDN, "R7 power-down entry");
        step(0, 2'b00, 3'b111, 0, 0, 0, V_PDN, "R7 wakes ignored");
        step(1, 2'b00, 3'b000, 0, 0, 0, V_PDN, "R9 active request in pdown");
        step(0, 2'b00, 3'b000, 0, 0, 1, V_ACT, "R7 regulator re-enable");
        idle(V_ACT, "R1 active steady");

        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule